// File: doc/BRIEF.md
# Cache Invalidation Strobe Generator

This block sits beside a bus master's write path and tells a host cache which lines the master has overwritten. For every write transfer it compares the transfer's word address with the line last announced. When the write lands in a different cache line, the block pulls an active-low address strobe for that one transfer. The host cache then snoops the address and invalidates the line. Writes that stay inside the line last announced produce no strobe.

The line size is set at run time by a 5-bit length field, counted in 32-bit words. A length of zero turns off boundary detection. With a length of zero, only the first write after the master gains the bus is announced. The remembered line is dropped on reset, when the master gives up the bus and when the mode is switched off. The next qualifying write after any of these therefore always strobes.

Top module: `cache_inval_strobe`

## Requirements
- R1: `inv_strobe_n` is active low. It is combinational and goes low only in the cycle in which the qualifying transfer's `wr_valid` is high, so each strobe lasts exactly one clock per transfer.
- R2: No strobe occurs while `inv_en` is low. While `inv_en` is low, the remembered line is cleared, so the first qualifying write after re-enabling strobes.
- R3: Only transfers with `bus_owned`, `mwr_active` and `wr_valid` all high qualify. Any other transfer, a read for example, neither strobes nor changes the remembered line.
- R4: The first qualifying write after `bus_owned` rises always strobes.
- R5: A qualifying write whose line tag equals the tag of the last strobed address produces no strobe.
- R6: Let L be `line_len`, bits [4:0], with L greater than 0, and let k = floor(log2 L). The effective line is 2^k words. The line tag is `wr_word_addr` shifted right by k. When a write's tag differs from the tag of the last strobed address, it strobes, and its address becomes the remembered one.
- R7: With `line_len` = 0, a qualifying write strobes only if no line is remembered.
- R8: The remembered line is cleared by reset, which is active low, and during any cycle in which `bus_owned` is low. No strobe is driven during reset.
- R9: A change of `line_len` takes effect on the next transfer, because the tag comparison applies the current length to the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_en | input | 1 | Invalidation mode enable |
| bus_owned | input | 1 | High while the master owns the bus |
| mwr_active | input | 1 | High while the master's current cycle is a write |
| wr_valid | input | 1 | One pulse per transfer |
| wr_word_addr | input | ADDR_W (30) | 32-bit word address of the transfer |
| line_len | input | LEN_W (5) | Cache line length in words |
| inv_strobe_n | output | 1 | Invalidation address strobe, active low |

## Verification
The assertions assume `bus_owned`, `inv_en` and `line_len` are steady inputs that change only between transfers. They also assume `wr_valid` is never high outside the master's ownership window unless it is meant to be ignored. The stimulus changes the mode, ownership and length fields only at clock edges, and it keeps each transfer's address stable for its valid cycle. Randomized phases do issue reads and out-of-ownership pulses on purpose, and the reference model holds the design to ignoring them.

// File: rtl/cache_inval_strobe.sv
module cache_inval_strobe #(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_en,
  input  logic              bus_owned,
  input  logic              mwr_active,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_word_addr,
  input  logic [LEN_W-1:0]  line_len,
  output logic              inv_strobe_n
);
  localparam int OFF_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;

  logic [ADDR_W-1:0] last_q;
  logic              have_q;
  logic [OFF_W-1:0]  offs;
  logic [ADDR_W-1:0] tag_mask;
  logic              qual_wr, tag_diff, new_line, hit;

  always_comb begin
    offs = '0;
    for (int i = 0; i < LEN_W; i++)
      if (line_len[i]) offs = i[OFF_W-1:0];
  end

  assign tag_mask = {ADDR_W{1'b1}} << offs;
  assign tag_diff = |((wr_word_addr ^ last_q) & tag_mask);
  assign qual_wr  = rst_n & inv_en & bus_owned & mwr_active & wr_valid;
  assign new_line = !have_q || ((line_len != '0) && tag_diff);
  assign hit      = qual_wr & new_line;
  assign inv_strobe_n = ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (!bus_owned || !inv_en) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (hit) begin
      have_q <= 1'b1;
      last_q <= wr_word_addr;
    end
  end
endmodule

module cache_inval_strobe_chk #(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_en,
  input logic              bus_owned,
  input logic              mwr_active,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_word_addr,
  input logic [LEN_W-1:0]  line_len,
  input logic              inv_strobe_n
);
  logic qw;
  assign qw = inv_en && bus_owned && mwr_active && wr_valid;

  p_strobe_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_strobe_n |-> (wr_valid && mwr_active && bus_owned));

  p_mode_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_en |-> inv_strobe_n);

  p_first_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qw && !$past(bus_owned)) |-> !inv_strobe_n);

  p_same_word_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qw && $past(qw) && $past(rst_n) && wr_word_addr == $past(wr_word_addr)) |-> inv_strobe_n);

  p_len_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (qw && $past(qw) && $past(rst_n) && line_len == '0) |-> inv_strobe_n);

  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_strobe_n && $past(rst_n)) |=> (inv_strobe_n || wr_valid));
endmodule

bind cache_inval_strobe cache_inval_strobe_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/cache_inval_strobe_tb.sv
module cache_inval_strobe_tb;
  localparam int AW = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_en = 0, bus_owned = 0, mwr_active = 0, wr_valid = 0;
  logic [AW-1:0] wr_word_addr = '0;
  logic [4:0] line_len = '0;
  logic inv_strobe_n;

  int n_run = 0, n_fail = 0;
  bit m_have = 0;
  logic [AW-1:0] m_last = '0;

  always #2 clk = ~clk;

  cache_inval_strobe u_dut (.*);

  function automatic bit model_hit();
    int k;
    bit diff;
    if (!rst_n || !(inv_en && bus_owned && mwr_active && wr_valid)) return 0;
    if (!m_have) return 1;
    if (line_len == 0) return 0;
    k = 0;
    for (int v = 1; v <= line_len; v = v * 2) if (v <= line_len) k++;
    k = k - 1;
    diff = (wr_word_addr >> k) != (m_last >> k);
    return diff;
  endfunction

  task automatic check(input bit exp_hit, input string tag);
    n_run++;
    if (inv_strobe_n !== !exp_hit) begin
      n_fail++;
      $display("FAIL %s: strobe_n=%b expected %b addr=%h", tag, inv_strobe_n, !exp_hit, wr_word_addr);
    end
  endtask

  task automatic cyc(input string tag, input int exp);
    bit mh;
    @(negedge clk);
    mh = model_hit();
    check(mh, tag);
    if (exp >= 0 && mh != exp[0]) begin
      n_run++; n_fail++;
      $display("FAIL %s: model=%0d expected %0d", tag, mh, exp);
    end
    @(posedge clk);
    if (!rst_n || !bus_owned || !inv_en) begin m_have = 0; m_last = '0; end
    else if (mh) begin m_have = 1; m_last = wr_word_addr; end
    #0.5;
  endtask

  task automatic drv(input bit own, input bit en, input bit mw, input bit v,
                     input logic [AW-1:0] a, input logic [4:0] len);
    bus_owned = own; inv_en = en; mwr_active = mw; wr_valid = v;
    wr_word_addr = a; line_len = len;
  endtask

  initial begin
    #40000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    drv(1, 1, 1, 1, 30'h40, 4);
    cyc("R8 reset quiet", 0);
    cyc("R8 reset quiet", 0);
    rst_n = 1;
    drv(1, 1, 1, 1, 30'h40, 4);   cyc("R4 first write", 1);
    drv(1, 1, 1, 1, 30'h41, 4);   cyc("R5 same line", 0);
    drv(1, 1, 1, 1, 30'h43, 4);   cyc("R5 same line end", 0);
    drv(1, 1, 1, 0, 30'h43, 4);   cyc("R1 idle", 0);
    drv(1, 1, 1, 1, 30'h44, 4);   cyc("R6 next line", 1);
    drv(1, 1, 1, 1, 30'h40, 4);   cyc("R6 back to line", 1);
    drv(1, 1, 0, 1, 30'h80, 4);   cyc("R3 read ignored", 0);
    drv(1, 1, 1, 1, 30'h42, 4);   cyc("R3 line kept", 0);
    drv(1, 1, 1, 1, 30'h43, 5);   cyc("R6 len5 as 4", 0);
    drv(1, 1, 1, 1, 30'h44, 5);   cyc("R6 len5 boundary", 1);
    drv(1, 1, 1, 1, 30'h47, 8);   cyc("R9 len8 same", 0);
    drv(1, 1, 1, 1, 30'h48, 1);   cyc("R9 len1 new word", 1);
    drv(1, 1, 1, 1, 30'h49, 1);   cyc("R9 len1 next word", 1);
    drv(1, 1, 1, 1, 30'h1000, 0); cyc("R7 len0 far", 0);
    drv(0, 1, 0, 0, 30'h0, 0);    cyc("R8 release", 0);
    drv(1, 1, 1, 1, 30'h1000, 0); cyc("R4 regrant", 1);
    drv(1, 1, 1, 1, 30'h2000, 0); cyc("R7 len0 quiet", 0);
    drv(1, 0, 1, 1, 30'h3000, 16); cyc("R2 mode off", 0);
    drv(1, 1, 1, 1, 30'h1000, 16); cyc("R2 re-enable", 1);
    drv(0, 1, 1, 1, 30'h5000, 16); cyc("R3 not owned", 0);
    drv(1, 1, 1, 1, 30'h1000, 16); cyc("R8 cleared by release", 1);
    for (int i = 0; i < 3000; i++) begin
      drv(($urandom_range(0, 15) != 0), ($urandom_range(0, 15) != 0),
          ($urandom_range(0, 5) != 0), $urandom_range(0, 1),
          30'h100 + 30'($urandom_range(0, 63)),
          ($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31)) : line_len);
      cyc("R6 random stream", -1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule